// File: doc/BRIEF.md
# Compare-Match Timer with Forced Output Action

This block is an up-counting timer with two compare channels. A small register port lets software load and read back the count, the two compare values, the per-channel pin action and PWM gate, and the prescaler select. Software can also strobe a forced action on either channel and clear the prescaler. Each channel drives one output pin and one sticky flag. A pin changes when the counter steps onto that channel's compare value, or when software forces the channel. The flag records only real matches.

The counter steps on an enable taken from a free-running prescaler. The prescaler divides the clock by 1, 8, 64 or 256, and its idle select codes stop the timer. Counter writes pass through a small sequencer with three named states. **STOP** is the state when no valid prescaler select is set. **RUN** is the state where ticks advance the count. **LOAD** holds a written value for one clock before it lands. The transitions are:
- STOP→RUN when a valid select appears.
- RUN→STOP when the select becomes invalid.
- STOP→LOAD or RUN→LOAD on any counter write.
- LOAD→LOAD on another write.
- LOAD→RUN or LOAD→STOP, depending on the select, once the loaded value lands.

A channel matches only when a counting step lands on its compare value. When software loads the counter or the compare register so that the two values are equal, the channel does not match.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count, both compare values, the control readback, the prescaler select, both pins and both flags are zero.
- R2: The count rises by one on each prescaler tick and wraps from 255 to 0. The prescaler select sits at address 4, bits [2:0]. Code 1 ticks every clock, 2 every 8th, 3 every 64th and 4 every 256th. Codes 0 and 5 to 7 stop the count. When the timer was stopped, the first step after writing select 1 lands on the second clock edge after the write edge.
- R3: A counter write goes to address 0. It is held one extra clock: readback still shows the old value right after the write edge and shows the new value one edge later.
- R4: A channel matches only when a counting step lands on its compare value. Loading the count to equal a compare value causes no match. Loading a compare value equal to the count also causes no match.
- R5: A channel flag is set one clock after the step that brought the count onto the compare value. The flags are read at address 5, bit i for channel i. Writing one to a bit clears that flag, and writing zero leaves it set.
- R6: The pin action is taken on the same edge that sets the flag. Control register address 3 holds the action for channel 0 in bits [1:0] and for channel 1 in bits [3:2]. The codes are 00 pin unchanged, 01 toggle, 10 drive low and 11 drive high.
- R7: Writing one to the force bit (control bit 4 for channel 0, bit 5 for channel 1) applies that channel's action at the write edge. A force never sets the flag.
- R8: A force uses the action code written in the same control write.
- R9: The force bits always read back as zero. A force is ignored when the channel's PWM gate is set in that write (control bit 6 for channel 0, bit 7 for channel 1).
- R10: Writing one to bit 3 of address 4 clears the prescaler and leaves the count unchanged. The bit reads back as zero. With select 2, the first step after such a write lands on the eighth edge after the write edge.
- R11: The compare values sit at address 1 (channel 0) and address 2 (channel 1) and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| cmp_pin | output | 2 | Compare output pin per channel |
| cmp_flag | output | 2 | Sticky compare flag per channel |

## Verification
Each result has its own latency, counted in rising edges after the edge that samples a write:
- A readback of a control, compare or prescaler write is correct as soon as that edge has passed.
- A forced pin change is also visible at that edge.
- A counter load is visible one edge later.
- After select 1 is written from a stopped state, the first step lands two edges later.
- A match pin change and flag follow one edge after the count reaches the compare value.

Inputs are driven and outputs sampled on the falling edge. Each scenario waits an exact number of rising edges before it samples, so every check reads its result in the cycle where the value is first due. Where a result must stay absent, the check holds it for several further cycles.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int NCH = 2;

    typedef enum logic [2:0] {
        RA_COUNT = 3'd0,
        RA_CMP0  = 3'd1,
        RA_CMP1  = 3'd2,
        RA_CTRL  = 3'd3,
        RA_PRESC = 3'd4,
        RA_FLAGS = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        ACT_OFF = 2'b00,
        ACT_TOG = 2'b01,
        ACT_CLR = 2'b10,
        ACT_SET = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        CS_STOP = 2'd0,
        CS_RUN  = 2'd1,
        CS_LOAD = 2'd2
    } cnt_state_e;

    localparam int CTL_FORCE_LSB = 4;
    localparam int CTL_PWM_LSB   = 6;
    localparam int PSC_CLR_BIT   = 3;
    localparam int SEL_W         = 3;

endpackage

// File: rtl/cmp_timer_psc.sv
module cmp_timer_psc
    import cmp_timer_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             clr_i,
    output logic             run_o,
    output logic             tick_o
);

    localparam int TAP_8   = 3;
    localparam int TAP_64  = 6;
    localparam int TAP_256 = 8;
    localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

    logic [PW-1:0] psc_q;

    always_comb begin
        run_o  = 1'b1;
        tick_o = 1'b0;
        case (sel_i)
            3'd1:    tick_o = 1'b1;
            3'd2:    tick_o = &psc_q[TAP_8-1:0];
            3'd3:    tick_o = &psc_q[TAP_64-1:0];
            3'd4:    tick_o = &psc_q[TAP_256-1:0];
            default: run_o  = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (clr_i) begin
            psc_q <= '0;
        end else if (run_o) begin
            psc_q <= psc_q + ONE;
        end
    end

    // R10: a prescaler clear leaves the divider at zero on the next cycle
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (psc_q == '0));

endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count
    import cmp_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         tick_i,
    input  logic         run_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] next_o,
    output logic         adv_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    cnt_state_e   state_q, state_d;
    logic [W-1:0] load_q;
    logic [W-1:0] count_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_STOP: begin
                if (wr_i)       state_d = CS_LOAD;
                else if (run_i) state_d = CS_RUN;
            end
            CS_RUN: begin
                if (wr_i)        state_d = CS_LOAD;
                else if (!run_i) state_d = CS_STOP;
            end
            CS_LOAD: begin
                if (wr_i)       state_d = CS_LOAD;
                else if (run_i) state_d = CS_RUN;
                else            state_d = CS_STOP;
            end
            default: state_d = CS_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_STOP;
            load_q  <= '0;
        end else begin
            state_q <= state_d;
            if (wr_i) load_q <= wdata_i;
        end
    end

    assign adv_o  = (state_q == CS_RUN) && tick_i && !wr_i;
    assign next_o = count_q + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (state_q == CS_LOAD) begin
            count_q <= load_q;
        end else if (adv_o) begin
            count_q <= next_o;
        end
    end

    assign count_o = count_q;

    // R3: a held load lands in the counter one clock later
    p_load_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_LOAD) |=> (count_q == $past(load_q)));

    // R2: each granted step raises the count by exactly one
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |=> (count_q == $past(count_q) + ONE));

endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
    import cmp_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    input  logic [W-1:0] cnt_next_i,
    input  logic         cmp_wr_i,
    input  logic [W-1:0] cmp_wdata_i,
    input  logic         ctrl_wr_i,
    input  logic [1:0]   mode_wdata_i,
    input  logic         force_wdata_i,
    input  logic         pwm_wdata_i,
    input  logic         flag_clr_i,
    output logic [W-1:0] cmp_o,
    output logic [1:0]   mode_o,
    output logic         pwm_o,
    output logic         pin_o,
    output logic         flag_o
);

    logic [W-1:0] cmp_q;
    act_e         mode_q;
    act_e         mode_eff;
    logic         pwm_q;
    logic         match_q;
    logic         pin_q;
    logic         flag_q;
    logic         force_act;
    logic         act;
    logic         pin_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= ACT_OFF;
            pwm_q  <= 1'b0;
        end else begin
            if (cmp_wr_i) cmp_q <= cmp_wdata_i;
            if (ctrl_wr_i) begin
                mode_q <= act_e'(mode_wdata_i);
                pwm_q  <= pwm_wdata_i;
            end
        end
    end

    // match only from a counting step landing on the compare value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= adv_i && (cnt_next_i == cmp_q);
    end

    assign force_act = ctrl_wr_i && force_wdata_i && !pwm_wdata_i;
    assign act       = match_q || force_act;
    assign mode_eff  = force_act ? act_e'(mode_wdata_i) : mode_q;

    always_comb begin
        pin_d = pin_q;
        if (act) begin
            unique case (mode_eff)
                ACT_OFF: pin_d = pin_q;
                ACT_TOG: pin_d = ~pin_q;
                ACT_CLR: pin_d = 1'b0;
                ACT_SET: pin_d = 1'b1;
                default: pin_d = pin_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            pin_q <= pin_d;
            if (match_q)         flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
        end
    end

    assign cmp_o  = cmp_q;
    assign mode_o = mode_q;
    assign pwm_o  = pwm_q;
    assign pin_o  = pin_q;
    assign flag_o = flag_q;

    // R4: a match event always follows a granted counting step
    p_match_needs_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |-> $past(adv_i));

    // R5 / R7: the flag rises only after a real match, never from a force
    p_flag_only_by_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !match_q |=> !$rose(flag_q));

    // R6: the pin moves only on a match or an accepted force
    p_pin_needs_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_q && !force_act) |=> $stable(pin_q));

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int W  = 8,
    parameter int PW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic [1:0]   cmp_pin,
    output logic [1:0]   cmp_flag
);

    localparam logic [2:0] CMP_BASE = RA_CMP0;

    logic [SEL_W-1:0] sel_q;
    logic             psc_clr;
    logic             run;
    logic             tick;
    logic             cnt_wr;
    logic [W-1:0]     count;
    logic [W-1:0]     cnt_next;
    logic             adv;
    logic [W-1:0]     cmp_arr  [NCH];
    logic [1:0]       mode_arr [NCH];
    logic [NCH-1:0]   pwm_vec;
    logic [W-1:0]     ctrl_rd;

    assign cnt_wr  = wr_en && (addr == RA_COUNT);
    assign psc_clr = wr_en && (addr == RA_PRESC) && wdata[PSC_CLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            sel_q <= '0;
        else if (wr_en && (addr == RA_PRESC))  sel_q <= wdata[SEL_W-1:0];
    end

    cmp_timer_psc #(.PW(PW)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel_q),
        .clr_i  (psc_clr),
        .run_o  (run),
        .tick_o (tick)
    );

    cmp_timer_count #(.W(W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cnt_wr),
        .wdata_i (wdata),
        .tick_i  (tick),
        .run_i   (run),
        .count_o (count),
        .next_o  (cnt_next),
        .adv_o   (adv)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cmp_timer_chan #(.W(W)) u_chan (
            .clk           (clk),
            .rst_n         (rst_n),
            .adv_i         (adv),
            .cnt_next_i    (cnt_next),
            .cmp_wr_i      (wr_en && (addr == CMP_BASE + 3'(i))),
            .cmp_wdata_i   (wdata),
            .ctrl_wr_i     (wr_en && (addr == RA_CTRL)),
            .mode_wdata_i  (wdata[2*i +: 2]),
            .force_wdata_i (wdata[CTL_FORCE_LSB + i]),
            .pwm_wdata_i   (wdata[CTL_PWM_LSB + i]),
            .flag_clr_i    (wr_en && (addr == RA_FLAGS) && wdata[i]),
            .cmp_o         (cmp_arr[i]),
            .mode_o        (mode_arr[i]),
            .pwm_o         (pwm_vec[i]),
            .pin_o         (cmp_pin[i]),
            .flag_o        (cmp_flag[i])
        );
    end

    always_comb begin
        ctrl_rd = '0;
        for (int i = 0; i < NCH; i++) begin
            ctrl_rd[2*i +: 2]         = mode_arr[i];
            ctrl_rd[CTL_PWM_LSB + i]  = pwm_vec[i];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_COUNT: rdata = count;
            RA_CMP0:  rdata = cmp_arr[0];
            RA_CMP1:  rdata = cmp_arr[1];
            RA_CTRL:  rdata = ctrl_rd;
            RA_PRESC: rdata[SEL_W-1:0] = sel_q;
            RA_FLAGS: rdata[NCH-1:0]   = cmp_flag;
            default:  rdata = '0;
        endcase
    end

    // R2: the counter never moves while the select stops the timer
    p_stopped_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr && $past(!cnt_wr)) |=> $stable(count));

endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [1:0] cmp_pin;
    logic [1:0] cmp_flag;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmp_timer u_cmp_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .cmp_pin  (cmp_pin),
        .cmp_flag (cmp_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 6; a++) begin
            peek(3'(a), v);
            chk("R1", $sformatf("reg %0d after reset", a), v, 0);
        end
        chk("R1", "pins after reset", cmp_pin, 0);
        chk("R1", "flags after reset", cmp_flag, 0);
    endtask

    task automatic t_cmp_rw();
        logic [7:0] v;
        wr(3'd2, 8'hA5);
        peek(3'd2, v);
        chk("R11", "compare 1 readback", v, 8'hA5);
        wr(3'd1, 8'h3C);
        peek(3'd1, v);
        chk("R11", "compare 0 readback", v, 8'h3C);
        wr(3'd2, 8'h00);
        peek(3'd2, v);
        chk("R11", "compare 1 restored", v, 0);
    endtask

    task automatic t_match_toggle();
        logic [7:0] v;
        wr(3'd1, 8'd10);
        wr(3'd3, 8'h01);
        wr(3'd0, 8'd7);
        wr(3'd4, 8'h01);
        peek(3'd0, v);
        chk("R2", "count before first step", v, 7);
        step(4);
        peek(3'd0, v);
        chk("R2", "count reaches compare", v, 10);
        chk("R5", "flag not yet set", cmp_flag[0], 0);
        chk("R6", "pin not yet toggled", cmp_pin[0], 0);
        step(1);
        chk("R5", "flag set one clock after match", cmp_flag[0], 1);
        chk("R6", "toggle action on match", cmp_pin[0], 1);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_flag_clear();
        wr(3'd5, 8'h00);
        chk("R5", "zero write keeps flag", cmp_flag[0], 1);
        wr(3'd5, 8'h01);
        chk("R5", "one write clears flag", cmp_flag[0], 0);
    endtask

    task automatic t_force();
        logic [7:0] v;
        wr(3'd3, 8'h12);
        chk("R8", "force with new clear code", cmp_pin[0], 0);
        chk("R7", "force sets no flag", cmp_flag[0], 0);
        peek(3'd3, v);
        chk("R9", "force bits read zero", v, 8'h02);
        wr(3'd3, 8'h13);
        chk("R8", "force with new set code", cmp_pin[0], 1);
        wr(3'd3, 8'h52);
        chk("R9", "force gated by PWM", cmp_pin[0], 1);
        peek(3'd3, v);
        chk("R9", "PWM readback without force", v, 8'h42);
        wr(3'd3, 8'h2C);
        chk("R7", "force on channel 1", cmp_pin[1], 1);
        chk("R7", "channel 0 untouched", cmp_pin[0], 1);
        step(2);
        chk("R7", "no flags after forces", cmp_flag, 0);
    endtask

    task automatic t_equal_writes();
        wr(3'd3, 8'h0D);
        wr(3'd1, 8'h30);
        wr(3'd0, 8'h30);
        step(4);
        chk("R4", "count load equal to compare: pin", cmp_pin[0], 1);
        chk("R4", "count load equal to compare: flag", cmp_flag[0], 0);
        wr(3'd0, 8'h44);
        wr(3'd2, 8'h44);
        step(4);
        chk("R4", "compare load equal to count: flag", cmp_flag[1], 0);
    endtask

    task automatic t_load_latency();
        logic [7:0] v;
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd0; wdata = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        peek(3'd0, v);
        chk("R3", "old count right after write edge", v, 8'h44);
        step(1);
        peek(3'd0, v);
        chk("R3", "new count one edge later", v, 8'h55);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h0E);
        wr(3'd0, 8'd254);
        wr(3'd4, 8'h01);
        step(3);
        peek(3'd0, v);
        chk("R2", "count wraps to zero", v, 0);
        chk("R6", "clear action not yet taken", cmp_pin[0], 1);
        step(1);
        chk("R6", "clear action on wrap match", cmp_pin[0], 0);
        chk("R5", "both flags set on wrap match", cmp_flag, 2'b11);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_presc();
        logic [7:0] c0;
        logic [7:0] v;
        peek(3'd0, c0);
        wr(3'd4, 8'h0A);
        peek(3'd4, v);
        chk("R10", "clear bit reads zero", v, 8'h02);
        peek(3'd0, v);
        chk("R10", "prescaler clear keeps count", v, c0);
        step(7);
        peek(3'd0, v);
        chk("R10", "no step before eighth edge", v, c0);
        step(1);
        peek(3'd0, v);
        chk("R10", "step on eighth edge", v, 8'(c0 + 8'd1));
        wr(3'd4, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmp_rw();
        t_match_toggle();
        t_flag_clear();
        t_force();
        t_equal_writes();
        t_load_latency();
        t_wrap();
        t_presc();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule